// File: doc/BRIEF.md
# Hidden-Layer Stochastic Weight Updater

This block runs the learning step for the first weight layer of a binary-output feed-forward network. On a start pulse it visits each hidden neuron in turn. For each one it makes a training decision from two random gates. The first gate opens when the neuron's pre-threshold sum is close to zero. The second opens when the error sent back from the output layer is large. Both are judged against random thresholds, and the neuron is trained only when both gates are open.

A trained neuron has every incoming weight, the bias weight included, moved by exactly one step through a single-port-style memory interface: one read and one write issued per clock. The direction of each step comes from the sign of the back-propagated error combined with the input bit that feeds the weight. Weights saturate at the limits of their signed width. Forward evaluation and the output-layer update happen elsewhere. The hidden sums, the error accumulators and the input bits must stay stable from start until done.

Top module: `hidden_wupd`

## Requirements
- R1: Neuron j passes the nearness gate when |sum_j| <= (rnd_a * lim_a) >> RND_W, where the magnitude of the most negative sum is taken exactly (for example -32768 has magnitude 32768). Both random inputs are sampled in that neuron's decision cycle.
- R2: Neuron j passes the error gate when |err_j| > (rnd_b * lim_b) >> RND_W. An error of zero never passes.
- R3: A neuron that fails either gate is skipped. None of its weights are read or written, and it takes one clock.
- R4: When err_j > 0, weight (j,i) gains 1 if input bit i is 1 and loses 1 if the bit is 0.
- R5: When err_j <= 0, the direction is reversed: weight (j,i) loses 1 if input bit i is 1 and gains 1 if the bit is 0.
- R6: Weight (j,i) lives at address j*(N_IN+1)+i. Index i = N_IN is the bias weight, whose input is treated as a constant 1 and which is updated with the others.
- R7: A step never wraps. A weight at the largest positive value does not grow, and a weight at the most negative value does not shrink.
- R8: Each weight is read at cycle t and written at cycle t+1 to the same address. A run lasts (N_IN+2) clocks per trained neuron plus 1 per skipped neuron plus 1 completion clock. busy_o is high for exactly that many clocks, and done_o pulses for one clock at the end.
- R9: A start pulse that arrives while a run is in progress is ignored. It neither restarts nor extends the run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a pass over all hidden neurons |
| in_bits_i | input | N_IN | Input-layer bit vector (bias not included) |
| hid_sum_i | input | N_HID*ACC_W | Signed pre-threshold sums, neuron j at bits [j*ACC_W +: ACC_W] |
| err_acc_i | input | N_HID*ACC_W | Signed back-propagated error, neuron j at bits [j*ACC_W +: ACC_W] |
| rnd_a_i | input | RND_W | Random source for the nearness gate |
| rnd_b_i | input | RND_W | Random source for the error gate |
| lim_a_i | input | LIM_W | Range limit for the nearness threshold |
| lim_b_i | input | LIM_W | Range limit for the error threshold |
| mem_rd_en_o | output | 1 | Weight read request |
| mem_rd_addr_o | output | ADDR_W | Weight read address |
| mem_rd_data_i | input | WGT_W | Read data, valid the clock after the request |
| mem_wr_en_o | output | 1 | Weight write request |
| mem_wr_addr_o | output | ADDR_W | Weight write address |
| mem_wr_data_o | output | WGT_W | Updated weight |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-clock pulse at the end of a run |

## Verification
The bench targets the exact gate boundaries. A sum whose magnitude equals the threshold must train and an error equal to its threshold must not, so a design with a wrong comparison on either side changes a whole row of weights. A sum at the most negative value checks the magnitude: a design that truncates the negation gets the wrong decision. Weights placed at both saturation limits catch a step that wraps, and the bias weight checks that the last index of each row is updated with an input of 1. Run lengths, a second start pulse in the middle of a run, and negative and zero errors check the timing rule, the start-ignore rule and the direction reversal. A design that mis-handles any of these either touches weights it should leave alone or reports the wrong number of busy clocks.

// File: rtl/hwu_pkg.sv
package hwu_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GATE = 2'd1,
    ST_STEP = 2'd2,
    ST_FIN  = 2'd3
  } hwu_state_e;

  // Step direction: 1 means +1, 0 means -1.
  // Positive error follows the input bit; otherwise the bit is inverted.
  function automatic logic step_up(input logic err_pos, input logic in_bit);
    return (in_bit == err_pos);
  endfunction

endpackage

// File: rtl/hwu_gate.sv
module hwu_gate #(
  parameter int ACC_W = 16,
  parameter int LIM_W = 16,
  parameter int RND_W = 8
) (
  input  logic signed [ACC_W-1:0] sum_i,
  input  logic signed [ACC_W-1:0] err_i,
  input  logic [RND_W-1:0]        rnd_a_i,
  input  logic [RND_W-1:0]        rnd_b_i,
  input  logic [LIM_W-1:0]        lim_a_i,
  input  logic [LIM_W-1:0]        lim_b_i,
  output logic                    near_o,
  output logic                    large_o,
  output logic                    err_pos_o
);
  localparam int MAG_W  = ACC_W + 1;
  localparam int PW     = RND_W + LIM_W;
  localparam int SHW    = MAG_W + RND_W;
  localparam int CMP_W  = (SHW > PW) ? SHW : PW;

  logic [MAG_W-1:0] sum_ext, err_ext, sum_mag, err_mag;
  logic [PW-1:0]    prod_a, prod_b;
  logic [CMP_W-1:0] lhs_a, lhs_b, rhs_a, rhs_b;

  // Magnitudes carry one extra bit so the most negative value is exact.
  assign sum_ext = {sum_i[ACC_W-1], sum_i};
  assign err_ext = {err_i[ACC_W-1], err_i};
  assign sum_mag = sum_ext[MAG_W-1] ? (~sum_ext + 1'b1) : sum_ext;
  assign err_mag = err_ext[MAG_W-1] ? (~err_ext + 1'b1) : err_ext;

  // Full-width products; a threshold of floor(P / 2^RND_W) is compared
  // as (m << RND_W) against P, which keeps every product bit in use.
  assign prod_a = {{LIM_W{1'b0}}, rnd_a_i} * {{RND_W{1'b0}}, lim_a_i};
  assign prod_b = {{LIM_W{1'b0}}, rnd_b_i} * {{RND_W{1'b0}}, lim_b_i};

  assign lhs_a = CMP_W'({sum_mag, {RND_W{1'b0}}});
  assign lhs_b = CMP_W'({err_mag, {RND_W{1'b0}}});
  assign rhs_a = CMP_W'(prod_a);
  assign rhs_b = CMP_W'(prod_b);

  assign near_o    = (lhs_a <= rhs_a);
  assign large_o   = (lhs_b >  rhs_b);
  assign err_pos_o = ~err_i[ACC_W-1] & (|err_i);
endmodule

// File: rtl/hwu_step.sv
module hwu_step #(
  parameter int WGT_W = 16
) (
  input  logic [WGT_W-1:0] w_i,
  input  logic             up_i,
  output logic [WGT_W-1:0] w_o
);
  localparam logic [WGT_W-1:0] W_MAX = {1'b0, {(WGT_W-1){1'b1}}};
  localparam logic [WGT_W-1:0] W_MIN = {1'b1, {(WGT_W-1){1'b0}}};

  always_comb begin
    if (up_i) begin
      w_o = (w_i == W_MAX) ? W_MAX : (w_i + 1'b1);
    end else begin
      w_o = (w_i == W_MIN) ? W_MIN : (w_i - 1'b1);
    end
  end
endmodule

// File: rtl/hwu_seq.sv
module hwu_seq
  import hwu_pkg::*;
#(
  parameter int N_IN   = 8,
  parameter int N_HID  = 4,
  parameter int ADDR_W = 6,
  parameter int NID_W  = 2,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              fire_i,
  input  logic              err_pos_i,
  input  logic [N_IN-1:0]   in_bits_i,
  output logic [NID_W-1:0]  nidx_o,
  output logic              in_gate_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_pend_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              wr_up_o
);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(N_IN + 1);
  localparam logic [NID_W-1:0]  LAST_N = NID_W'(N_HID - 1);
  localparam logic [IDX_W-1:0]  LAST_I = IDX_W'(N_IN);

  hwu_state_e        state;
  logic [NID_W-1:0]  nidx;
  logic [IDX_W-1:0]  iidx;
  logic [ADDR_W-1:0] base;
  logic              errpos_q;
  logic              pend;
  logic [ADDR_W-1:0] pend_addr;
  logic              pend_up;
  logic [N_IN:0]     ext_bits;
  logic              last_n, last_i, rd_en;
  logic [ADDR_W-1:0] rd_addr;

  // Bias input sits at the top index with a constant 1.
  assign ext_bits = {1'b1, in_bits_i};
  assign last_n   = (nidx == LAST_N);
  assign last_i   = (iidx == LAST_I);
  assign rd_en    = (state == ST_STEP);
  assign rd_addr  = base + ADDR_W'(iidx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      nidx      <= '0;
      iidx      <= '0;
      base      <= '0;
      errpos_q  <= 1'b0;
      pend      <= 1'b0;
      pend_addr <= '0;
      pend_up   <= 1'b0;
    end else begin
      pend <= rd_en;
      if (rd_en) begin
        pend_addr <= rd_addr;
        pend_up   <= step_up(errpos_q, ext_bits[iidx]);
      end
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            state <= ST_GATE;
            nidx  <= '0;
            base  <= '0;
          end
        end
        ST_GATE: begin
          if (fire_i) begin
            state    <= ST_STEP;
            iidx     <= '0;
            errpos_q <= err_pos_i;
          end else if (last_n) begin
            state <= ST_FIN;
          end else begin
            nidx <= nidx + NID_W'(1);
            base <= base + STRIDE;
          end
        end
        ST_STEP: begin
          if (last_i) begin
            iidx <= '0;
            if (last_n) begin
              state <= ST_FIN;
            end else begin
              state <= ST_GATE;
              nidx  <= nidx + NID_W'(1);
              base  <= base + STRIDE;
            end
          end else begin
            iidx <= iidx + IDX_W'(1);
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign nidx_o    = nidx;
  assign in_gate_o = (state == ST_GATE);
  assign busy_o    = (state != ST_IDLE);
  assign done_o    = (state == ST_FIN);
  assign rd_en_o   = rd_en;
  assign rd_addr_o = rd_addr;
  assign wr_pend_o = pend;
  assign wr_addr_o = pend_addr;
  assign wr_up_o   = pend_up;
endmodule

// File: rtl/hidden_wupd.sv
module hidden_wupd #(
  parameter int N_IN  = 8,
  parameter int N_HID = 4,
  parameter int ACC_W = 16,
  parameter int WGT_W = 16,
  parameter int LIM_W = 16,
  parameter int RND_W = 8,
  parameter int DEPTH  = N_HID * (N_IN + 1),
  parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [N_IN-1:0]        in_bits_i,
  input  logic [N_HID*ACC_W-1:0] hid_sum_i,
  input  logic [N_HID*ACC_W-1:0] err_acc_i,
  input  logic [RND_W-1:0]       rnd_a_i,
  input  logic [RND_W-1:0]       rnd_b_i,
  input  logic [LIM_W-1:0]       lim_a_i,
  input  logic [LIM_W-1:0]       lim_b_i,
  output logic                   mem_rd_en_o,
  output logic [ADDR_W-1:0]      mem_rd_addr_o,
  input  logic [WGT_W-1:0]       mem_rd_data_i,
  output logic                   mem_wr_en_o,
  output logic [ADDR_W-1:0]      mem_wr_addr_o,
  output logic [WGT_W-1:0]       mem_wr_data_o,
  output logic                   busy_o,
  output logic                   done_o
);
  localparam int NID_W = (N_HID > 1) ? $clog2(N_HID) : 1;
  localparam int IDX_W = $clog2(N_IN + 1);

  logic [NID_W-1:0]        nidx;
  logic                    in_gate;
  logic signed [ACC_W-1:0] cur_sum, cur_err;
  logic                    near_w, large_w, err_pos_w;
  logic                    gate_fire_w;
  logic                    wr_up_w;

  assign cur_sum = hid_sum_i[nidx*ACC_W +: ACC_W];
  assign cur_err = err_acc_i[nidx*ACC_W +: ACC_W];

  hwu_gate #(.ACC_W(ACC_W), .LIM_W(LIM_W), .RND_W(RND_W)) gate_i (
    .sum_i     (cur_sum),
    .err_i     (cur_err),
    .rnd_a_i   (rnd_a_i),
    .rnd_b_i   (rnd_b_i),
    .lim_a_i   (lim_a_i),
    .lim_b_i   (lim_b_i),
    .near_o    (near_w),
    .large_o   (large_w),
    .err_pos_o (err_pos_w)
  );

  // Training event for the neuron under decision.
  assign gate_fire_w = in_gate & near_w & large_w;

  hwu_seq #(
    .N_IN(N_IN), .N_HID(N_HID), .ADDR_W(ADDR_W), .NID_W(NID_W), .IDX_W(IDX_W)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .fire_i    (gate_fire_w),
    .err_pos_i (err_pos_w),
    .in_bits_i (in_bits_i),
    .nidx_o    (nidx),
    .in_gate_o (in_gate),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .rd_en_o   (mem_rd_en_o),
    .rd_addr_o (mem_rd_addr_o),
    .wr_pend_o (mem_wr_en_o),
    .wr_addr_o (mem_wr_addr_o),
    .wr_up_o   (wr_up_w)
  );

  hwu_step #(.WGT_W(WGT_W)) step_i (
    .w_i  (mem_rd_data_i),
    .up_i (wr_up_w),
    .w_o  (mem_wr_data_o)
  );
endmodule

// File: rtl/hwu_chk.sv
module hwu_chk #(
  parameter int WGT_W  = 16,
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [WGT_W-1:0]  rd_data,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [WGT_W-1:0]  wr_data,
  input logic              gate_fire
);
  localparam logic [WGT_W-1:0] W_MAX = {1'b0, {(WGT_W-1){1'b1}}};
  localparam logic [WGT_W-1:0] W_MIN = {1'b1, {(WGT_W-1){1'b0}}};

  logic signed [WGT_W:0] diff;
  assign diff = $signed({wr_data[WGT_W-1], wr_data}) - $signed({rd_data[WGT_W-1], rd_data});

  // R8
  rd_to_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (wr_en && wr_addr == $past(rd_addr)));

  // R7
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (diff == 1 || diff == -1 ||
               (diff == 0 && (rd_data == W_MAX || rd_data == W_MIN))));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R3
  fire_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_fire |=> rd_en);

  // R6
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (32'(rd_addr) < DEPTH));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) |-> busy);
endmodule

bind hidden_wupd hwu_chk #(.WGT_W(WGT_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy_o),
  .done      (done_o),
  .rd_en     (mem_rd_en_o),
  .rd_addr   (mem_rd_addr_o),
  .rd_data   (mem_rd_data_i),
  .wr_en     (mem_wr_en_o),
  .wr_addr   (mem_wr_addr_o),
  .wr_data   (mem_wr_data_o),
  .gate_fire (gate_fire_w)
);

// File: tb/hidden_wupd_tb_top.sv
module hidden_wupd_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_IN  = 8;
  localparam int N_HID = 4;
  localparam int ACC_W = 16;
  localparam int WGT_W = 16;
  localparam int LIM_W = 16;
  localparam int RND_W = 8;
  localparam int DEPTH = N_HID * (N_IN + 1);
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N_IN-1:0]        in_bits = '0;
  logic [N_HID*ACC_W-1:0] sums = '0;
  logic [N_HID*ACC_W-1:0] errs = '0;
  logic [RND_W-1:0]       rnd_a = '0, rnd_b = '0;
  logic [LIM_W-1:0]       lim_a = '0, lim_b = '0;
  logic                   rd_en, wr_en, busy, done;
  logic [AW-1:0]          rd_addr, wr_addr;
  logic [WGT_W-1:0]       rd_data = '0;
  logic [WGT_W-1:0]       wr_data;

  logic [WGT_W-1:0] mem [DEPTH];
  int sum_v [N_HID];
  int err_v [N_HID];
  int exp_w [DEPTH];
  int trained;
  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hidden_wupd #(
    .N_IN(N_IN), .N_HID(N_HID), .ACC_W(ACC_W), .WGT_W(WGT_W),
    .LIM_W(LIM_W), .RND_W(RND_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .in_bits_i(in_bits),
    .hid_sum_i(sums), .err_acc_i(errs), .rnd_a_i(rnd_a), .rnd_b_i(rnd_b),
    .lim_a_i(lim_a), .lim_b_i(lim_b),
    .mem_rd_en_o(rd_en), .mem_rd_addr_o(rd_addr), .mem_rd_data_i(rd_data),
    .mem_wr_en_o(wr_en), .mem_wr_addr_o(wr_addr), .mem_wr_data_o(wr_data),
    .busy_o(busy), .done_o(done)
  );

  // Weight memory model: registered read, write at the clock edge.
  always @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  task automatic check(input string tag, input bit ok, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic apply_inputs();
    for (int j = 0; j < N_HID; j++) begin
      sums[j*ACC_W +: ACC_W] = ACC_W'(sum_v[j]);
      errs[j*ACC_W +: ACC_W] = ACC_W'(err_v[j]);
    end
  endtask

  task automatic fill_mem(input int seed);
    for (int a = 0; a < DEPTH; a++) mem[a] = WGT_W'(a * 731 - 9000 + seed);
  endtask

  // Reference model written from the requirements.
  task automatic build_expect();
    int ra, rb, ms, me, w;
    bit b, pos;
    ra = (int'(rnd_a) * int'(lim_a)) / (1 << RND_W);
    rb = (int'(rnd_b) * int'(lim_b)) / (1 << RND_W);
    trained = 0;
    for (int a = 0; a < DEPTH; a++) exp_w[a] = int'($signed(mem[a]));
    for (int j = 0; j < N_HID; j++) begin
      ms = (sum_v[j] < 0) ? -sum_v[j] : sum_v[j];
      me = (err_v[j] < 0) ? -err_v[j] : err_v[j];
      if (ms <= ra && me > rb) begin
        trained++;
        pos = (err_v[j] > 0);
        for (int i = 0; i <= N_IN; i++) begin
          b = (i == N_IN) ? 1'b1 : in_bits[i];
          w = exp_w[j*(N_IN+1) + i];
          if (b == pos) w = (w == 32767) ? w : w + 1;
          else          w = (w == -32768) ? w : w - 1;
          exp_w[j*(N_IN+1) + i] = w;
        end
      end
    end
  endtask

  task automatic run_and_check(input string tag, input bit restart);
    int cyc, dn, guard, expc;
    build_expect();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 0; dn = 0; guard = 0;
    while (busy && guard < 5000) begin
      cyc++;
      if (done) dn++;
      start = (restart && cyc == 3);
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    check({tag, " R8 watchdog"}, guard < 5000, guard, 5000);
    expc = trained * (N_IN + 2) + (N_HID - trained) + 1;
    check({tag, " R8 busy cycles"}, cyc == expc, cyc, expc);
    check({tag, " R8 done pulses"}, dn == 1, dn, 1);
    for (int a = 0; a < DEPTH; a++)
      check($sformatf("%s weight[%0d]", tag, a),
            int'($signed(mem[a])) == exp_w[a], int'($signed(mem[a])), exp_w[a]);
  endtask

  task automatic set_all(input int s, input int e);
    for (int j = 0; j < N_HID; j++) begin sum_v[j] = s; err_v[j] = e; end
  endtask

  task automatic t_reset();
    check("R8 reset busy", busy == 1'b0, int'(busy), 0);
    check("R8 reset done", done == 1'b0, int'(done), 0);
    check("R8 reset rd_en", rd_en == 1'b0, int'(rd_en), 0);
    check("R8 reset wr_en", wr_en == 1'b0, int'(wr_en), 0);
  endtask

  task automatic t_pos_err();
    fill_mem(0);
    in_bits = 8'b1010_0110;
    set_all(0, 1000);
    rnd_a = 8'd0; lim_a = 16'd0; rnd_b = 8'd0; lim_b = 16'd0;
    apply_inputs();
    run_and_check("R4 R6 positive error", 1'b0);
  endtask

  task automatic t_neg_err();
    fill_mem(3);
    in_bits = 8'b0110_1001;
    set_all(0, -700);
    err_v[2] = 0;
    rnd_a = 8'd0; lim_a = 16'd0; rnd_b = 8'd0; lim_b = 16'd0;
    apply_inputs();
    run_and_check("R5 R3 non-positive error", 1'b0);
  endtask

  task automatic t_gate_near();
    fill_mem(11);
    in_bits = 8'b1100_0011;
    rnd_a = 8'd128; lim_a = 16'd400;
    rnd_b = 8'd0;   lim_b = 16'd0;
    sum_v[0] = 200;  err_v[0] = 500;
    sum_v[1] = 201;  err_v[1] = 500;
    sum_v[2] = -200; err_v[2] = -500;
    sum_v[3] = -201; err_v[3] = 500;
    apply_inputs();
    run_and_check("R1 nearness boundary", 1'b0);
  endtask

  task automatic t_gate_large();
    fill_mem(-5);
    in_bits = 8'b0001_1110;
    rnd_a = 8'd0;   lim_a = 16'd0;
    rnd_b = 8'd128; lim_b = 16'd400;
    set_all(0, 0);
    err_v[0] = 200; err_v[1] = 201; err_v[2] = -201; err_v[3] = -200;
    apply_inputs();
    run_and_check("R2 error boundary", 1'b0);
  endtask

  task automatic t_min_sum();
    fill_mem(7);
    in_bits = 8'b1111_0000;
    rnd_a = 8'd255; lim_a = 16'hFFFF;
    rnd_b = 8'd0;   lim_b = 16'd0;
    set_all(-32768, 9);
    sum_v[1] = 32767;
    err_v[3] = -32768;
    apply_inputs();
    run_and_check("R1 most negative sum", 1'b0);
  endtask

  task automatic t_saturate();
    fill_mem(0);
    in_bits = 8'b0101_0101;
    for (int i = 0; i <= N_IN; i++) begin
      mem[i]           = (i == N_IN || in_bits[i]) ? 16'h7FFF : 16'h8000;
      mem[N_IN + 1 + i] = (i == N_IN || in_bits[i]) ? 16'h8000 : 16'h7FFF;
    end
    rnd_a = 8'd0; lim_a = 16'd0; rnd_b = 8'd0; lim_b = 16'd0;
    set_all(0, 50);
    err_v[1] = -50;
    apply_inputs();
    run_and_check("R7 saturation", 1'b0);
  endtask

  task automatic t_restart_ignored();
    fill_mem(21);
    in_bits = 8'b1001_0110;
    rnd_a = 8'd0; lim_a = 16'd0; rnd_b = 8'd0; lim_b = 16'd0;
    set_all(0, 40);
    sum_v[0] = 5;
    apply_inputs();
    run_and_check("R9 start during run", 1'b1);
  endtask

  task automatic t_all_skip();
    fill_mem(13);
    in_bits = 8'hFF;
    rnd_a = 8'd0; lim_a = 16'd0; rnd_b = 8'd0; lim_b = 16'd0;
    set_all(3, 400);
    apply_inputs();
    run_and_check("R3 all neurons skipped", 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pos_err();
    t_neg_err();
    t_gate_near();
    t_gate_large();
    t_min_sum();
    t_saturate();
    t_restart_ignored();
    t_all_skip();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule